// File: doc/BRIEF.md
# DAC Output Update Controller

This block decides which code drives a voltage-output converter at any moment. It sits between the register file, which holds the programmed DAC register and the clearcode register, and the converter's code input. Three active-low control pins are used: load, clear and reset. Three single-cycle software strobes, decoded by the serial front end from its software control word, are also used. From these it chooses whether the output code follows the DAC register, is forced to the clearcode, or goes back to its power-on value.

All pin inputs pass through a synchroniser chain into the system clock domain, where the level and edge decisions are made. Clear outranks load. While a clear is in force, the block asks the register file to copy the clearcode into the DAC register, so a later load does not bring back a stale value. While the reset pin is low, the block raises a write-lock flag that the front end uses to drop programming. When the reset pin returns high, it sends a one-cycle request for every register to return to its default.

Top module: `dac_update_ctrl`

## Requirements
- R1: While the synchronised reset pin is low, `write_lock` is 1, `out_code` is 0, `dac_clr_load` stays 0, and the clear and load inputs (pins or strobes) have no effect.
- R2: When the reset pin returns high, `reg_reset_req` is high for exactly one cycle and `write_lock` returns to 0.
- R3: While the clear pin is low and reset is inactive, `out_code` equals `clear_code` and `dac_clr_load` is 1, whatever the load pin level.
- R4: While clear is high and the load pin is held low, `out_code` follows `dac_reg_q` with one cycle of delay.
- R5: A falling edge on the load pin with clear high updates `out_code` from `dac_reg_q`. After the load pin returns high, `out_code` holds even when `dac_reg_q` changes.
- R6: When the clear pin rises with the load pin high, `out_code` stays at the clearcode. When the clear pin rises with the load pin low, `out_code` follows `dac_reg_q`.
- R7: The load strobe `sw_ctrl[0]`, when both pins are high, copies `dac_reg_q` to `out_code` on the next cycle. While the load pin is low, the strobe has no effect.
- R8: The clear strobe `sw_ctrl[1]` sets `out_code` to `clear_code` and pulses `dac_clr_load` for one cycle. While the clear pin is low, the strobe has no effect.
- R9: The reset strobe `sw_ctrl[2]`, while the reset pin is high, gives a one-cycle `reg_reset_req` and sets `out_code` to 0 on the next cycle.
- R10: A pin change reaches the outputs after the `SYNC_STAGES`-deep synchroniser plus one register, which is 3 cycles at the defaults.
- R11: While `rst_n` is low, `out_code` is 0 and `write_lock`, `reg_reset_req` and `dac_clr_load` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ldac_pin_n | input | 1 | Load pin, active low, asynchronous |
| clr_pin_n | input | 1 | Clear pin, active low, asynchronous |
| reset_pin_n | input | 1 | Device reset pin, active low, asynchronous |
| sw_ctrl | input | 3 | Single-cycle strobes: bit 0 load, bit 1 clear, bit 2 reset |
| dac_reg_q | input | CODE_W | Current DAC register value |
| clear_code | input | CODE_W | Current clearcode register value |
| out_code | output | CODE_W | Code driven to the converter |
| write_lock | output | 1 | High while programming must be ignored |
| reg_reset_req | output | 1 | One-cycle request to return all registers to defaults |
| dac_clr_load | output | 1 | Request to copy the clearcode into the DAC register |

## Verification
A wrong source choice appears on `out_code` within one cycle of the synchronised decision, and at most three cycles after a pin moves. The bench separates hold from follow by changing `dac_reg_q` while the load pin is high. If the clear-rise hold state is lost, the output moves to the DAC register value instead of keeping the clearcode. A broken reset edge detector appears as a missing or doubled `reg_reset_req` pulse, so the bench counts the pulses over a window instead of sampling once.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

  localparam int unsigned SW_LDAC_BIT  = 0;
  localparam int unsigned SW_CLR_BIT   = 1;
  localparam int unsigned SW_RESET_BIT = 2;
  localparam int unsigned SW_W         = 3;

  typedef enum logic [1:0] {
    SRC_HOLD  = 2'd0,
    SRC_ZERO  = 2'd1,
    SRC_CLEAR = 2'd2,
    SRC_DAC   = 2'd3
  } out_src_e;

endpackage

// File: rtl/dac_upd_sync.sv
module dac_upd_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_async;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/dac_upd_edge.sv
module dac_upd_edge #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= RST_VAL;
    end else begin
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;

endmodule

// File: rtl/dac_upd_sel.sv
module dac_upd_sel
  import dac_upd_pkg::*;
(
  input  logic            rst_lvl,
  input  logic            rst_rise,
  input  logic            clr_lvl,
  input  logic            ldac_lvl,
  input  logic [SW_W-1:0] sw_ctrl,
  output out_src_e        src,
  output logic            clr_load,
  output logic            reg_rst
);

  always_comb begin
    src      = SRC_HOLD;
    clr_load = 1'b0;
    reg_rst  = 1'b0;
    if (!rst_lvl) begin
      src = SRC_ZERO;
    end else if (rst_rise || sw_ctrl[SW_RESET_BIT]) begin
      src     = SRC_ZERO;
      reg_rst = 1'b1;
    end else if (!clr_lvl || sw_ctrl[SW_CLR_BIT]) begin
      src      = SRC_CLEAR;
      clr_load = 1'b1;
    end else if (!ldac_lvl || sw_ctrl[SW_LDAC_BIT]) begin
      src = SRC_DAC;
    end
  end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
  import dac_upd_pkg::*;
#(
  parameter int unsigned CODE_W      = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldac_pin_n,
  input  logic              clr_pin_n,
  input  logic              reset_pin_n,
  input  logic [SW_W-1:0]   sw_ctrl,
  input  logic [CODE_W-1:0] dac_reg_q,
  input  logic [CODE_W-1:0] clear_code,
  output logic [CODE_W-1:0] out_code,
  output logic              write_lock,
  output logic              reg_reset_req,
  output logic              dac_clr_load
);

  localparam int unsigned PIN_W = 3;
  localparam int unsigned P_LDAC = 0;
  localparam int unsigned P_CLR  = 1;
  localparam int unsigned P_RST  = 2;

  logic [PIN_W-1:0] pins_async;
  logic [PIN_W-1:0] pins_sync;
  logic             rst_rise;
  out_src_e         src;
  logic             clr_load_d;
  logic             reg_rst_d;
  logic [CODE_W-1:0] out_code_d;
  logic              out_en;

  assign pins_async[P_LDAC] = ldac_pin_n;
  assign pins_async[P_CLR]  = clr_pin_n;
  assign pins_async[P_RST]  = reset_pin_n;

  dac_upd_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL ({PIN_W{1'b1}})
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pins_async),
    .q_sync  (pins_sync)
  );

  dac_upd_edge #(
    .W       (1),
    .RST_VAL (1'b1)
  ) u_rst_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pins_sync[P_RST]),
    .rise  (rst_rise)
  );

  dac_upd_sel u_sel (
    .rst_lvl  (pins_sync[P_RST]),
    .rst_rise (rst_rise),
    .clr_lvl  (pins_sync[P_CLR]),
    .ldac_lvl (pins_sync[P_LDAC]),
    .sw_ctrl  (sw_ctrl),
    .src      (src),
    .clr_load (clr_load_d),
    .reg_rst  (reg_rst_d)
  );

  always_comb begin
    out_en     = (src != SRC_HOLD);
    out_code_d = out_code;
    case (src)
      SRC_ZERO:  out_code_d = '0;
      SRC_CLEAR: out_code_d = clear_code;
      SRC_DAC:   out_code_d = dac_reg_q;
      default:   out_code_d = out_code;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_code <= '0;
    end else if (out_en) begin
      out_code <= out_code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_reset_req <= 1'b0;
      dac_clr_load  <= 1'b0;
    end else begin
      reg_reset_req <= reg_rst_d;
      dac_clr_load  <= clr_load_d;
    end
  end

  assign write_lock = ~pins_sync[P_RST];

endmodule

// File: rtl/dac_update_ctrl_chk.sv
module dac_update_ctrl_chk #(
  parameter int unsigned CODE_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        sw_ctrl,
  input logic [CODE_W-1:0] clear_code,
  input logic [CODE_W-1:0] out_code,
  input logic              write_lock,
  input logic              reg_reset_req,
  input logic              dac_clr_load
);

  AST_LOCK_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    write_lock |=> (out_code == '0)); // R1

  AST_LOCK_NO_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    write_lock |=> !dac_clr_load); // R1

  AST_RESET_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset_req |=> !reg_reset_req); // R2

  AST_CLR_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dac_clr_load |-> (out_code == $past(clear_code))); // R3

  AST_SW_RESET_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ctrl[2] && !write_lock) |=> (reg_reset_req && out_code == '0)); // R9

  always_comb begin
    if (!rst_n) begin
      AST_ASYNC_RESET_IDLE: assert (!reg_reset_req && !dac_clr_load); // R11
    end
  end

endmodule

bind dac_update_ctrl dac_update_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_ctrl       (sw_ctrl),
  .clear_code    (clear_code),
  .out_code      (out_code),
  .write_lock    (write_lock),
  .reg_reset_req (reg_reset_req),
  .dac_clr_load  (dac_clr_load)
);

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;

  localparam int unsigned CW = 20;

  logic          clk;
  logic          rst_n;
  logic          ldac_pin_n;
  logic          clr_pin_n;
  logic          reset_pin_n;
  logic [2:0]    sw_ctrl;
  logic [CW-1:0] dac_reg_q;
  logic [CW-1:0] clear_code;
  logic [CW-1:0] out_code;
  logic          write_lock;
  logic          reg_reset_req;
  logic          dac_clr_load;

  int n_checks = 0;
  int n_bad    = 0;
  bit finished = 0;

  dac_update_ctrl #(.CODE_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ldac_pin_n    (ldac_pin_n),
    .clr_pin_n     (clr_pin_n),
    .reset_pin_n   (reset_pin_n),
    .sw_ctrl       (sw_ctrl),
    .dac_reg_q     (dac_reg_q),
    .clear_code    (clear_code),
    .out_code      (out_code),
    .write_lock    (write_lock),
    .reg_reset_req (reg_reset_req),
    .dac_clr_load  (dac_clr_load)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sw_pulse(input logic [2:0] v);
    @(negedge clk);
    sw_ctrl = v;
    @(negedge clk);
    sw_ctrl = 3'b000;
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; ldac_pin_n = 1'b1; clr_pin_n = 1'b1; reset_pin_n = 1'b1;
    sw_ctrl = 3'b000; dac_reg_q = 20'h12345; clear_code = 20'hFFFFF;
    cyc(3);
    check("R11 out_code", out_code, '0);
    check("R11 write_lock", CW'(write_lock), '0);
    check("R11 reg_reset_req", CW'(reg_reset_req), '0);
    check("R11 dac_clr_load", CW'(dac_clr_load), '0);
    rst_n = 1'b1;
    cyc(4);
    check("R11 out after release", out_code, '0);
  endtask

  task automatic t_transparent;
    ldac_pin_n = 1'b0;
    cyc(2);
    check("R10 not yet at 2 cycles", out_code, '0);
    cyc(1);
    check("R10 out after 3 cycles", out_code, 20'h12345);
    dac_reg_q = 20'h0A0A0;
    cyc(1);
    check("R4 follows dac reg", out_code, 20'h0A0A0);
    sw_pulse(3'b001);
    check("R7 strobe ignored with ldac low", out_code, 20'h0A0A0);
  endtask

  task automatic t_ldac_edge;
    ldac_pin_n = 1'b1;
    cyc(5);
    dac_reg_q = 20'h55555;
    cyc(3);
    check("R5 holds with ldac high", out_code, 20'h0A0A0);
    ldac_pin_n = 1'b0;
    cyc(5);
    check("R5 falling edge loads", out_code, 20'h55555);
    ldac_pin_n = 1'b1;
    cyc(5);
    dac_reg_q = 20'h77777;
    cyc(3);
    check("R5 holds after return high", out_code, 20'h55555);
    sw_pulse(3'b001);
    check("R7 software load", out_code, 20'h77777);
  endtask

  task automatic t_clear_pin;
    clear_code = 20'hFFFFF;
    clr_pin_n = 1'b0;
    cyc(5);
    check("R3 clear forces code", out_code, 20'hFFFFF);
    check("R3 clear load level", CW'(dac_clr_load), 20'h1);
    ldac_pin_n = 1'b0;
    cyc(5);
    check("R3 clear beats ldac low", out_code, 20'hFFFFF);
    ldac_pin_n = 1'b1;
    sw_pulse(3'b010);
    check("R8 strobe no effect under clear pin", CW'(dac_clr_load), 20'h1);
    cyc(1);
    check("R8 clear pin load stays", CW'(dac_clr_load), 20'h1);
    clr_pin_n = 1'b1;
    cyc(5);
    check("R6 rise with ldac high holds", out_code, 20'hFFFFF);
    check("R6 clear load ends", CW'(dac_clr_load), '0);
    ldac_pin_n = 1'b0;
    clr_pin_n = 1'b0;
    cyc(5);
    clr_pin_n = 1'b1;
    cyc(5);
    check("R6 rise with ldac low follows", out_code, 20'h77777);
    ldac_pin_n = 1'b1;
    cyc(5);
  endtask

  task automatic t_sw_clear;
    clear_code = 20'h3C3C3;
    sw_pulse(3'b010);
    check("R8 software clear code", out_code, 20'h3C3C3);
    check("R8 software clear load", CW'(dac_clr_load), 20'h1);
    cyc(1);
    check("R8 load pulse one cycle", CW'(dac_clr_load), '0);
  endtask

  task automatic t_sw_reset;
    sw_pulse(3'b100);
    check("R9 reset request", CW'(reg_reset_req), 20'h1);
    check("R9 output zero", out_code, '0);
    cyc(1);
    check("R9 request one cycle", CW'(reg_reset_req), '0);
  endtask

  task automatic t_reset_pin;
    int pulses;
    sw_pulse(3'b001);
    check("R7 reload before reset pin", out_code, 20'h77777);
    reset_pin_n = 1'b0;
    cyc(5);
    check("R1 lock high", CW'(write_lock), 20'h1);
    check("R1 output zero", out_code, '0);
    sw_pulse(3'b010);
    check("R1 soft clear ignored", out_code, '0);
    check("R1 no clear load", CW'(dac_clr_load), '0);
    clr_pin_n = 1'b0;
    ldac_pin_n = 1'b0;
    cyc(5);
    check("R1 pins ignored", out_code, '0);
    check("R1 no clear load pin", CW'(dac_clr_load), '0);
    clr_pin_n = 1'b1;
    ldac_pin_n = 1'b1;
    cyc(5);
    pulses = 0;
    reset_pin_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (reg_reset_req) pulses++;
    end
    check("R2 single reset request", CW'(pulses), 20'h1);
    check("R2 lock released", CW'(write_lock), '0);
  endtask

  initial begin
    t_reset_state();
    t_transparent();
    t_ldac_edge();
    t_clear_pin();
    t_sw_clear();
    t_sw_reset();
    t_reset_pin();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule